// File: doc/BRIEF.md
# Partial Scan Chain Wrapper

This block holds a small state machine whose state register is W flip-flops wide. Its next state comes from a fixed feedback-shift function of the current state and a one-bit functional input. An elaboration-time mask picks which of those flip-flops are also scan cells. Only the picked cells are linked into a serial shift path. The others have no scan access and are only observable, never directly loadable.

A scheme parameter selects how the chain is clocked. In the system-clock scheme, every system clock edge with scan enabled shifts the chain by one place, while the unmasked flops keep loading their functional next state. The test start state is therefore the shifted-in scan bits combined with whatever the unmasked flops hold at that moment. In the dual-clock scheme, a separate scan clock shifts only the masked cells. The unmasked cells freeze for as long as scan is enabled.

The serial path has no valid/ready handshake. It moves by one place on every qualifying clock edge, so it cannot apply back-pressure, and the tester must present the next scan bit before each such edge.

Top module: `partial_scan_wrap`

## Requirements
- R1: While rst_n is low, every state bit is 0 and scan_out is 0.
- R2: With scan_en low, each system clock edge loads the functional next state: bit 0 takes state[W-1] XOR state[TAP] XOR func_in, and bit i (for i > 0) takes state[i-1]. The defaults are W=12 and TAP=6.
- R3: The chain runs in ascending bit order over the masked bits. In the system-clock scheme with scan_en high, on each system clock edge the lowest masked bit takes scan_in and every other masked bit takes the next lower masked bit. The default mask is 12'hA69, which selects bits 0, 3, 5, 6, 9 and 11.
- R4: In the system-clock scheme with scan_en high, the unmasked bits load their functional next state from R2 on the same edge as the shift.
- R5: scan_out equals the highest masked state bit.
- R6: In the dual-clock scheme with scan_en high, each rising scan_clk edge shifts the masked bits by one place as in R3, and system clock edges leave the masked bits unchanged.
- R7: In the dual-clock scheme with scan_en high, the unmasked bits keep their value across both clocks.
- R8: In the dual-clock scheme with scan_en low, scan_clk edges change no state bit.
- R9: With an empty mask, scan_out is 0 and all bits follow R2 even when scan_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_clk | input | 1 | Scan clock, used by the dual-clock scheme only |
| scan_en | input | 1 | Selects shifting of the masked cells |
| scan_in | input | 1 | Serial input to the lowest masked bit |
| func_in | input | 1 | Functional input bit fed into the feedback |
| state_q | output | W | Present state of all flip-flops |
| scan_out | output | 1 | Highest masked bit, or 0 when the mask is empty |

## Verification
In the system-clock scheme, each result appears at the first rising clk edge after the inputs change. The bench drives inputs on the falling edge and compares on the next falling edge, which is exactly one register stage later. In the dual-clock scheme, a shift is due at the scan_clk rising edge. The bench pulses scan_clk and samples inside the same low phase of clk, then samples again after the next clk edge to confirm that the system clock moved nothing. scan_out is wired straight from a state bit, so it is compared in the same sample as the state it follows.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int MAXW = 64;

  typedef enum logic {
    SCHEME_SYS  = 1'b0,
    SCHEME_DUAL = 1'b1
  } psc_scheme_e;

  // Nearest masked bit below position i, or -1 when bit i heads the chain.
  function automatic int prev_scan(logic [MAXW-1:0] m, int i);
    int r;
    r = -1;
    for (int k = 0; k < i; k++) if (m[k]) r = k;
    return r;
  endfunction

  function automatic int first_scan(logic [MAXW-1:0] m, int w);
    int r;
    r = -1;
    for (int k = w - 1; k >= 0; k--) if (m[k]) r = k;
    return r;
  endfunction

  function automatic int last_scan(logic [MAXW-1:0] m, int w);
    int r;
    r = -1;
    for (int k = 0; k < w; k++) if (m[k]) r = k;
    return r;
  endfunction
endpackage

// File: rtl/psc_next_state.sv
module psc_next_state #(
  parameter int W   = 12,
  parameter int TAP = 6
) (
  input  logic [W-1:0] cur,
  input  logic         fin,
  output logic [W-1:0] nxt
);
  always_comb begin
    nxt = {cur[W-2:0], cur[W-1] ^ cur[TAP] ^ fin};
  end
endmodule

// File: rtl/psc_cell.sv
module psc_cell #(
  parameter bit IS_SCAN = 1'b0,
  parameter bit DUAL    = 1'b0
) (
  input  logic clk,
  input  logic scan_clk,
  input  logic rst_n,
  input  logic scan_en,
  input  logic d_func,
  input  logic d_scan,
  output logic q
);
  logic unused_cell;
  assign unused_cell = ^{scan_clk, d_scan, scan_en};

  if (DUAL && IS_SCAN) begin : g_dual_scan
    logic cell_clk;
    assign cell_clk = scan_en ? scan_clk : clk;
    always_ff @(posedge cell_clk or negedge rst_n) begin
      if (!rst_n)       q <= 1'b0;
      else if (scan_en) q <= d_scan;
      else              q <= d_func;
    end
  end else if (DUAL) begin : g_dual_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (!scan_en) q <= d_func;
    end
  end else if (IS_SCAN) begin : g_sys_scan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= 1'b0;
      else if (scan_en) q <= d_scan;
      else              q <= d_func;
    end
  end else begin : g_plain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d_func;
    end
  end
endmodule

// File: rtl/partial_scan_wrap.sv
module partial_scan_wrap #(
  parameter int                  W         = 12,
  parameter int                  TAP       = 6,
  parameter logic [W-1:0]        SCAN_MASK = 12'hA69,
  parameter psc_pkg::psc_scheme_e SCHEME   = psc_pkg::SCHEME_SYS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scan_clk,
  input  logic         scan_en,
  input  logic         scan_in,
  input  logic         func_in,
  output logic [W-1:0] state_q,
  output logic         scan_out
);
  localparam logic [psc_pkg::MAXW-1:0] MASK64 = psc_pkg::MAXW'(SCAN_MASK);
  localparam logic [W-1:0] M     = SCAN_MASK;
  localparam bit           DUAL  = (SCHEME == psc_pkg::SCHEME_DUAL);
  localparam int           FIRST = psc_pkg::first_scan(MASK64, W);
  localparam int           LAST  = psc_pkg::last_scan(MASK64, W);

  logic [W-1:0] nxt;

  psc_next_state #(.W(W), .TAP(TAP)) u_next (
    .cur (state_q),
    .fin (func_in),
    .nxt (nxt)
  );

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam int P = psc_pkg::prev_scan(MASK64, i);
    logic d_scan;
    if (P < 0) begin : g_head
      assign d_scan = scan_in;
    end else begin : g_link
      assign d_scan = state_q[P];
    end
    psc_cell #(.IS_SCAN(M[i]), .DUAL(DUAL)) u_cell (
      .clk      (clk),
      .scan_clk (scan_clk),
      .rst_n    (rst_n),
      .scan_en  (scan_en),
      .d_func   (nxt[i]),
      .d_scan   (d_scan),
      .q        (state_q[i])
    );
  end

  if (LAST < 0) begin : g_no_chain
    assign scan_out = 1'b0;
  end else begin : g_chain_tail
    assign scan_out = state_q[LAST];
  end

  // Checks kept beside the clocking variant they guard.
  if (DUAL) begin : g_chk_dual
    assert_func_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_en |=> (scan_en || state_q == $past(nxt)));
    assert_nonscan_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      scan_en |=> (!scan_en || ((state_q & ~M) == ($past(state_q) & ~M))));
  end else begin : g_chk_sys
    assert_func_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_en |=> (state_q == $past(nxt)));
    assert_nonscan_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
      scan_en |=> ((state_q & ~M) == ($past(nxt) & ~M)));
    if (FIRST >= 0) begin : g_chk_head
      assert_chain_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> (state_q[FIRST] == $past(scan_in)));
    end
  end
endmodule

// File: tb/tb_partial_scan_wrap.sv
`timescale 1ns/1ps
module tb_partial_scan_wrap;
  localparam logic [11:0] MSK = 12'hA69;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_en = 1'b0, s_in = 1'b0, f_in = 1'b0;
  logic t_en = 1'b0, t_in = 1'b0, t_fin = 1'b0, t_sclk = 1'b0;
  logic [11:0] st_sys, st_none, st_tc;
  logic so_sys, so_none, so_tc;
  int errors = 0;
  int checks = 0;
  logic [11:0] m_sys = '0, m_none = '0, m_tc = '0;

  always #2 clk = ~clk;

  partial_scan_wrap dut (
    .clk(clk), .rst_n(rst_n), .scan_clk(1'b0), .scan_en(s_en), .scan_in(s_in),
    .func_in(f_in), .state_q(st_sys), .scan_out(so_sys));

  partial_scan_wrap #(.SCAN_MASK(12'h000)) dut_none (
    .clk(clk), .rst_n(rst_n), .scan_clk(1'b0), .scan_en(s_en), .scan_in(s_in),
    .func_in(f_in), .state_q(st_none), .scan_out(so_none));

  partial_scan_wrap #(.SCHEME(psc_pkg::SCHEME_DUAL)) dut_tc (
    .clk(clk), .rst_n(rst_n), .scan_clk(t_sclk), .scan_en(t_en), .scan_in(t_in),
    .func_in(t_fin), .state_q(st_tc), .scan_out(so_tc));

  function automatic logic [11:0] ref_func(logic [11:0] s, logic f);
    return {s[10:0], s[11] ^ s[6] ^ f};
  endfunction

  function automatic logic [11:0] ref_shift(logic [11:0] s, logic [11:0] m, logic si);
    logic [11:0] r;
    logic carry;
    r = s;
    carry = si;
    for (int i = 0; i < 12; i++) begin
      if (m[i]) begin
        r[i] = carry;
        carry = s[i];
      end
    end
    return r;
  endfunction

  function automatic logic ref_out(logic [11:0] s, logic [11:0] m);
    logic r;
    r = 1'b0;
    for (int i = 0; i < 12; i++) if (m[i]) r = s[i];
    return r;
  endfunction

  task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {scan_en, scan_in, func_in}
  localparam logic [2:0] VEC [16] = '{
    3'b001, 3'b001, 3'b000, 3'b001, 3'b110, 3'b100, 3'b111, 3'b110,
    3'b101, 3'b110, 3'b000, 3'b011, 3'b101, 3'b111, 3'b001, 3'b000};

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 sys state", st_sys, 12'h000);
    chk("R1 dual state", st_tc, 12'h000);
    chk("R1 scan_out", {9'd0, so_sys, so_tc, so_none}, 12'h000);
    rst_n = 1'b1;

    foreach (VEC[k]) begin
      {s_en, s_in, f_in} = VEC[k];
      @(negedge clk);
      if (s_en) begin
        m_sys = (ref_shift(m_sys, MSK, s_in) & MSK) | (ref_func(m_sys, f_in) & ~MSK);
        chk("R3 R4 shift with functional non-scan", st_sys, m_sys);
        chk("R9 empty mask ignores scan_en", st_none, ref_func(m_none, f_in));
      end else begin
        m_sys = ref_func(m_sys, f_in);
        chk("R2 functional step", st_sys, m_sys);
        chk("R2 functional step empty mask", st_none, ref_func(m_none, f_in));
      end
      m_none = ref_func(m_none, f_in);
      chk("R5 scan_out tail", {11'd0, so_sys}, {11'd0, ref_out(m_sys, MSK)});
      chk("R9 scan_out zero", {11'd0, so_none}, 12'h000);
      // dual instance stays at its zero fixed point in this phase
      chk("R2 dual idle", st_tc, m_tc);
    end
    s_en = 1'b0;

    // dual-clock: functional steps to get a non-zero state
    for (int j = 0; j < 4; j++) begin
      t_fin = (j != 2);
      @(negedge clk);
      m_tc = ref_func(m_tc, t_fin);
      chk("R2 dual functional", st_tc, m_tc);
    end

    // dual-clock shifting
    t_fin = 1'b1;
    for (int j = 0; j < 5; j++) begin
      t_en = 1'b1;
      t_in = (j == 0 || j == 3);
      #0.5 t_sclk = 1'b1;
      #0.5 t_sclk = 1'b0;
      #0.3;
      m_tc = ref_shift(m_tc, MSK, t_in);
      chk("R6 scan_clk shift", st_tc, m_tc);
      chk("R5 dual scan_out", {11'd0, so_tc}, {11'd0, ref_out(m_tc, MSK)});
      @(negedge clk);
      chk("R6 R7 clk edge holds all", st_tc, m_tc);
    end

    // scan_clk with scan_en low has no effect
    t_en = 1'b0;
    #0.5 t_sclk = 1'b1;
    #0.5 t_sclk = 1'b0;
    #0.3;
    chk("R8 scan_clk ignored", st_tc, m_tc);

    // capture cycle from the scanned start state
    @(negedge clk);
    m_tc = ref_func(m_tc, t_fin);
    chk("R2 dual capture", st_tc, m_tc);

    // reset again mid-run
    rst_n = 1'b0;
    #0.5;
    chk("R1 async reset", st_sys | st_tc, 12'h000);
    @(negedge clk);
    rst_n = 1'b1;

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule